// File: doc/BRIEF.md
# Dual event performance counter unit

This block holds two identical event counters that software programs and reads over a simple register bus. Each counter has a 16-bit control register that picks one of 64 hardware event codes, chooses between per-CPU-cycle counting and a bus-ratio mode, and sets the run state. The count is `CNT_W` bits wide, 48 by default. It is read as two 32-bit data words: a high word holding the bits above `LO_W` and a low word holding the lower `LO_W` bits, 32 by default.

Events come from the core as a 64-bit vector indexed by event code. Occurrence codes carry one-cycle pulses. Cycle codes carry levels. The elapsed-time code ignores its input and counts every qualifying clock. A bus-clock enable strobe, high in one of every two CPU cycles, drives the ratio mode: in that mode a cycle-type event adds 12 per bus cycle instead of 1 per CPU cycle. A single control bit means two things. Written to a running counter it halts the counter and keeps the count. Written to a counter that is not running it clears the count. A counter whose run bits are not both set reads as zero but keeps its count internally. The count wraps with no flag and no interrupt.

Top module: `perf_counter_pair`

## Requirements
- R1: After reset, both control registers and all four data words read as 0, and both counters are disabled.
- R2: A control read returns the code in bits [5:0], the clock type in bit 8 and the run bits in [15:14] as stored. Bits 6, 7, 9 to 12 and 13 always read 0, and writes to bits 6, 7 and 9 to 12 have no effect.
- R3: A counter advances only while both run bits [15:14] are 1. A value of 01 or 10 counts nothing and reads as a disabled counter. The count never advances in the cycle of a write to its own control register.
- R4: Writing a control value with bit 13 set while the counter is running halts it. The count is held and stays readable, and the run bits read back as 00.
- R5: Writing a control value with bit 13 set while the counter is halted or disabled clears the count to 0. If that same write has run bits 11, counting restarts from 0.
- R6: Writing a control value with bit 13 clear and run bits other than 11 disables the counter. Both data words then read 0, but the count is kept, and a later write of run bits 11 resumes from the kept value.
- R7: With clock type 0, code 0x23 (elapsed time) adds 1 in every running cycle, whatever the event inputs are.
- R8: Codes 0x01 to 0x1A, except 0x0C, add 1 for each cycle in which `evt_in[code]` is high, with either clock type.
- R9: With clock type 0, codes 0x21 to 0x29, except 0x26 and 0x23, add 1 for each cycle in which `evt_in[code]` is high.
- R10: With clock type 1, the cycle codes 0x21 to 0x29 (except 0x26) add 12 in each cycle where `bus_tick` is high and the event is active, and add 0 in all other cycles. Code 0x23 is always active.
- R11: Codes 0x00, 0x0C, 0x1B to 0x20, 0x26 and 0x2A to 0x3F never change the count.
- R12: The count wraps modulo 2^CNT_W with no indication.
- R13: The address map is: word address 0 and 1 are the control registers of counters 0 and 1; addresses 2 and 3 are the high and low data words of counter 0; addresses 4 and 5 are those of counter 1; addresses 6 and 7 read 0. Writes to data addresses are ignored, and the two counters are independent.
- R14: A high-word read returns the count bits above `LO_W`, zero-extended, and captures the low bits at that cycle. The next low-word read of the same counter returns the captured value. A low-word read with no capture pending returns the live low bits.

Rdata is combinational: it is valid in the same cycle that `rd_en` and `addr` are applied, and it is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | Bus-clock enable, high one CPU cycle per bus cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Control write data |
| rdata | output | 32 | Read data, 0 when no read |
| evt_in | input | 64 | Event pulses and levels, indexed by event code |

## Verification
The wrap condition cannot be reached at the default width. The bench therefore builds a narrow configuration (a 14-bit count with an 8-bit low word) and runs the elapsed-time code through 2^14 plus a few cycles. The other hard case is the dual meaning of the stop bit. The bench reaches it by writing bit 13 once from the running state and again from the halted state, then by writing bit 13 together with run bits 11. The consistent high-then-low read is exercised on a counter that is still running, so the low word changes between the two reads. A sweep over all 64 event codes, alternating between the counters, drives each code's own input and checks the count class by class.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;

    localparam int CODE_W = 6;
    localparam int EVT_W  = 1 << CODE_W;
    localparam int CTRL_W = 16;

    localparam int CB_RATIO = 8;
    localparam int CB_STOP  = 13;

    localparam logic [CODE_W-1:0] CODE_TIME = 6'h23;

    localparam logic [3:0] RATIO_STEP = 4'd12;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } pc_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_OCC  = 2'd1,
        EV_CYC  = 2'd2,
        EV_TIME = 2'd3
    } ev_class_e;

    function automatic ev_class_e classify(input logic [CODE_W-1:0] code);
        if (code == CODE_TIME)
            return EV_TIME;
        else if (code >= 6'h01 && code <= 6'h1A && code != 6'h0C)
            return EV_OCC;
        else if (code >= 6'h21 && code <= 6'h29 && code != 6'h26)
            return EV_CYC;
        else
            return EV_NONE;
    endfunction

endpackage

// File: rtl/pc_event_qual.sv
module pc_event_qual
    import perfcnt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              ratio,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              bus_tick,
    output logic [3:0]        inc
);

    ev_class_e cls;
    logic      active;

    always_comb begin
        cls    = classify(code);
        active = evt_in[code] || (cls == EV_TIME);
        inc    = 4'd0;
        case (cls)
            EV_OCC: begin
                if (active) inc = 4'd1;
            end
            EV_CYC, EV_TIME: begin
                if (ratio) begin
                    if (active && bus_tick) inc = RATIO_STEP;
                end else if (active) begin
                    inc = 4'd1;
                end
            end
            default: inc = 4'd0;
        endcase
    end

endmodule

// File: rtl/pc_counter_slice.sv
module pc_counter_slice
    import perfcnt_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [3:0]        inc,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_visible,
    output logic [CODE_W-1:0] code,
    output logic              ratio
);

    typedef struct packed {
        pc_state_e         st;
        logic [CODE_W-1:0] code;
        logic              ratio;
        logic [1:0]        run;
        logic [CNT_W-1:0]  cnt;
    } slice_t;

    slice_t s_d, s_q;

    logic unused_rsvd;
    assign unused_rsvd = ^{ctrl_wdata[12:9], ctrl_wdata[7:6]};

    always_comb begin
        s_d = s_q;
        if (ctrl_wr) begin
            s_d.code  = ctrl_wdata[CODE_W-1:0];
            s_d.ratio = ctrl_wdata[CB_RATIO];
            if (ctrl_wdata[CB_STOP]) begin
                if (s_q.st == ST_RUN) begin
                    s_d.st  = ST_HALT;
                    s_d.run = 2'b00;
                end else begin
                    s_d.cnt = '0;
                    s_d.run = ctrl_wdata[15:14];
                    s_d.st  = (ctrl_wdata[15:14] == 2'b11) ? ST_RUN : ST_HALT;
                end
            end else begin
                s_d.run = ctrl_wdata[15:14];
                s_d.st  = (ctrl_wdata[15:14] == 2'b11) ? ST_RUN : ST_OFF;
            end
        end else if (s_q.st == ST_RUN) begin
            s_d.cnt = s_q.cnt + CNT_W'(inc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_OFF, code: '0, ratio: 1'b0, run: 2'b00, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_rd     = {s_q.run, 1'b0, 4'b0000, s_q.ratio, 2'b00, s_q.code};
    assign cnt         = s_q.cnt;
    assign cnt_visible = (s_q.st != ST_OFF);
    assign code        = s_q.code;
    assign ratio       = s_q.ratio;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_RUN && !ctrl_wr) |=> (cnt == $past(cnt))); // R3

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CB_STOP] && s_q.st == ST_RUN) |=> (cnt_visible && ctrl_rd[15:14] == 2'b00 && $stable(cnt))); // R4

    AST_IDLE_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CB_STOP] && s_q.st != ST_RUN) |=> (cnt == '0)); // R5

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && !ctrl_wr) |=> ((cnt - $past(cnt)) == CNT_W'(0) || (cnt - $past(cnt)) == CNT_W'(1) || (cnt - $past(cnt)) == CNT_W'(12))); // R10

endmodule

// File: rtl/perf_counter_pair.sv
module perf_counter_pair
    import perfcnt_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int LO_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [31:0]       rdata,
    input  logic [EVT_W-1:0]  evt_in
);

    localparam int NUM_CTR = 2;
    localparam int HI_W    = CNT_W - LO_W;

    logic [CTRL_W-1:0] ctrl_rd [NUM_CTR];
    logic [CNT_W-1:0]  cnt_w   [NUM_CTR];
    logic [NUM_CTR-1:0] vis;
    logic [CODE_W-1:0] code_w  [NUM_CTR];
    logic [NUM_CTR-1:0] ratio_w;
    logic [3:0]        inc_w   [NUM_CTR];
    logic [NUM_CTR-1:0] ctrl_wr;
    logic [NUM_CTR-1:0] rd_hi;
    logic [NUM_CTR-1:0] rd_lo;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        assign ctrl_wr[g] = wr_en && (addr == 3'(g));
        assign rd_hi[g]   = rd_en && (addr == 3'(2 + 2 * g));
        assign rd_lo[g]   = rd_en && (addr == 3'(3 + 2 * g));

        pc_event_qual i_qual (
            .code     (code_w[g]),
            .ratio    (ratio_w[g]),
            .evt_in   (evt_in),
            .bus_tick (bus_tick),
            .inc      (inc_w[g])
        );

        pc_counter_slice #(.CNT_W(CNT_W)) i_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_wr     (ctrl_wr[g]),
            .ctrl_wdata  (wdata),
            .inc         (inc_w[g]),
            .ctrl_rd     (ctrl_rd[g]),
            .cnt         (cnt_w[g]),
            .cnt_visible (vis[g]),
            .code        (code_w[g]),
            .ratio       (ratio_w[g])
        );
    end

    typedef struct packed {
        logic [NUM_CTR-1:0][LO_W-1:0] shadow;
        logic [NUM_CTR-1:0]           valid;
    } rd_state_t;

    rd_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_hi[i]) begin
                r_d.shadow[i] = cnt_w[i][LO_W-1:0];
                r_d.valid[i]  = 1'b1;
            end
            if (rd_lo[i]) begin
                r_d.valid[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_en && addr == 3'(i)) begin
                rdata = 32'(ctrl_rd[i]);
            end
            if (rd_hi[i] && vis[i]) begin
                rdata = 32'(cnt_w[i][CNT_W-1:LO_W]);
            end
            if (rd_lo[i] && vis[i]) begin
                rdata = r_q.valid[i] ? 32'(r_q.shadow[i]) : 32'(cnt_w[i][LO_W-1:0]);
            end
        end
    end

    AST_HI_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi[0] || rd_hi[1]) |-> ((rdata >> HI_W) == 32'd0)); // R14

    AST_LO_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi[0] && vis[0]) |=> (!(rd_lo[0] && vis[0]) || rdata == $past(32'(cnt_w[0][LO_W-1:0])))); // R14

    AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hi[0] || rd_lo[0]) && !vis[0]) |-> (rdata == 32'd0)); // R6

endmodule

// File: tb/test_perf_counter_pair.sv
`timescale 1ns/100ps
module test_perf_counter_pair;

    localparam int CNT_W = 14;
    localparam int LO_W  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] evt_in = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    perf_counter_pair #(.CNT_W(CNT_W), .LO_W(LO_W)) i_perf_counter_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_tick (bus_tick),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .evt_in   (evt_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic get_cnt(input int c, output logic [31:0] v);
        logic [31:0] hi, lo;
        rd(3'(2 + 2 * c), hi);
        rd(3'(3 + 2 * c), lo);
        v = (hi << LO_W) | lo;
    endtask

    // 0 none, 1 occurrence, 2 cycle level, 3 elapsed
    function automatic int kind(input int code);
        if (code == 'h23) return 3;
        if (code >= 1 && code <= 'h1A && code != 'h0C) return 1;
        if (code >= 'h21 && code <= 'h29 && code != 'h26) return 2;
        return 0;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R13 unused addresses
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reset read addr %0d", a), v, 32'd0);
        end

        // R2 reserved bits ignored, bit 13 reads 0
        wr(3'd0, 16'h1EC5);
        rd(3'd0, v); chk("R2 reserved ignored", v, 32'h0005);
        wr(3'd0, 16'h3FFF);
        rd(3'd0, v); chk("R2 stop bit reads 0", v, 32'h013F);

        // R13 data writes ignored
        wr(3'd0, 16'h2000);
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd0, 16'h6000);
        get_cnt(0, v); chk("R13 data write ignored", v, 32'd0);

        // R3 partial run bits never count
        wr(3'd0, 16'h2000);
        wr(3'd0, 16'h4023);
        repeat (20) @(posedge clk);
        rd(3'd3, v); chk("R3 run=01 reads zero", v, 32'd0);
        wr(3'd0, 16'h8023);
        repeat (20) @(posedge clk);
        wr(3'd0, 16'hC023);
        wr(3'd0, 16'hE023);
        get_cnt(0, v); chk("R3 run=01/10 did not count", v, 32'd0);

        // R7 elapsed time, R4 stop holds
        wr(3'd0, 16'h2000);
        wr(3'd0, 16'hC023);
        repeat (37) @(posedge clk);
        wr(3'd0, 16'hE023);
        rd(3'd0, v); chk("R4 halted run bits 00", v, 32'h0023);
        get_cnt(0, v); chk("R7 elapsed count", v, 32'd37);
        repeat (10) @(posedge clk);
        get_cnt(0, v); chk("R4 halted count held", v, 32'd37);
        wr(3'd0, 16'h2000);
        get_cnt(0, v); chk("R5 stop while halted clears", v, 32'd0);

        // R14 consistent high/low read while running
        wr(3'd0, 16'hC023);
        repeat (300) @(posedge clk);
        rd(3'd2, v); chk("R14 high word", v, 32'd1);
        repeat (10) @(posedge clk);
        rd(3'd3, v); chk("R14 low from capture", v, 32'd44);
        wr(3'd0, 16'hE023);
        rd(3'd3, v); chk("R14 live low", v, 32'd56);
        rd(3'd2, v); chk("R14 high after stop", v, 32'd1);

        // event code sweep: R8 R9 R11 R13
        for (int code = 0; code < 64; code++) begin
            int c, p, k, exp;
            c = code % 2;
            p = (code % 4) + 1;
            k = kind(code);
            wr(3'(c), 16'h2000);
            wr(3'(c), 16'hC000 | 16'(code));
            for (int i = 0; i < p; i++) begin
                @(negedge clk);
                evt_in = (k == 0) ? ~64'd0 : (64'd1 << code);
                @(negedge clk);
                evt_in = '0;
            end
            wr(3'(c), 16'hE000 | 16'(code));
            get_cnt(c, v);
            exp = (k == 0) ? 0 : (k == 3) ? 2 * p : p;
            if (k == 1)
                chk($sformatf("R8 occurrence code 0x%0h", code), v, 32'(exp));
            else if (k == 2)
                chk($sformatf("R9 cycle code 0x%0h", code), v, 32'(exp));
            else if (k == 3)
                chk($sformatf("R7 elapsed code 0x%0h", code), v, 32'(exp));
            else
                chk($sformatf("R11 unused code 0x%0h", code), v, 32'(exp));
        end

        // R8 occurrence ignores clock type
        wr(3'd1, 16'h2000);
        wr(3'd1, 16'hC105);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); evt_in = 64'd1 << 5; bus_tick = 1'b1;
            @(negedge clk); evt_in = '0; bus_tick = 1'b0;
        end
        wr(3'd1, 16'hE105);
        get_cnt(1, v); chk("R8 occurrence in ratio mode", v, 32'd3);

        // R10 ratio mode, elapsed
        wr(3'd0, 16'h2000);
        wr(3'd0, 16'hC123);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); bus_tick = 1'b1;
            @(negedge clk); bus_tick = 1'b0;
        end
        wr(3'd0, 16'hE123);
        get_cnt(0, v); chk("R10 ratio elapsed", v, 32'd84);

        // R10 ratio mode, level event active for 4 of 7 ticks
        wr(3'd0, 16'h2000);
        wr(3'd0, 16'hC124);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); bus_tick = 1'b1; evt_in = (i < 4) ? (64'd1 << 'h24) : '0;
            @(negedge clk); bus_tick = 1'b0;
        end
        evt_in = '0;
        wr(3'd0, 16'hE124);
        get_cnt(0, v); chk("R10 ratio level event", v, 32'd48);

        // R6 disable keeps count, R5 clear-and-start, R13 independence
        wr(3'd1, 16'h2000);
        wr(3'd1, 16'hC023);
        repeat (20) @(posedge clk);
        wr(3'd1, 16'h0023);
        rd(3'd4, v); chk("R6 disabled high reads 0", v, 32'd0);
        rd(3'd5, v); chk("R6 disabled low reads 0", v, 32'd0);
        rd(3'd1, v); chk("R6 disabled ctrl", v, 32'h0023);
        repeat (10) @(posedge clk);
        wr(3'd1, 16'hC023);
        repeat (30) @(posedge clk);
        wr(3'd1, 16'hE023);
        get_cnt(1, v); chk("R6 resume from kept count", v, 32'd50);
        wr(3'd1, 16'hE023);
        repeat (9) @(posedge clk);
        wr(3'd1, 16'hE023);
        get_cnt(1, v); chk("R5 clear with start", v, 32'd9);
        get_cnt(0, v); chk("R13 counter 0 unaffected", v, 32'd48);

        // R12 wrap
        wr(3'd0, 16'h2000);
        wr(3'd0, 16'hC023);
        repeat ((1 << CNT_W) + 5) @(posedge clk);
        wr(3'd0, 16'hE023);
        get_cnt(0, v); chk("R12 silent wrap", v, 32'd5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule